// File: doc/BRIEF.md
# Digital Wiper Position Controller

This block holds the setting of a digitally controlled potentiometer. An 8-bit wiper register picks one of 256 tap switches along a resistor string, and a registered one-hot select drives those switches. A bank of four 8-bit data registers keeps preset positions. Any preset can be copied into the wiper register in one cycle, and the current wiper value can be saved back into any preset.

A simple command port stands in for the serial front end. Each clock cycle it carries an operation code, a register index and a data byte. A separate step strobe moves the wiper one position up or down and stops at either end. An active-low write-protect input freezes every stored value. The presets stay readable through a read-select port at all times.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: `wiper_val` presents the 8-bit wiper register. It changes only on a rising clock edge and only through the operations in R4 to R9.
- R2: `tap_sel` bit i is set exactly when the wiper register holds i. Value 0x00 selects bit 0, the tap at the low terminal. Value 0xFF selects bit 255, the tap at the high terminal.
- R3: `tap_sel` is registered and has exactly one bit set in every cycle after reset. It changes on the same clock edge as `wiper_val`.
- R4: `cmd_op` = 1 (preset write) stores `cmd_data` into data register `cmd_sel`.
- R5: `cmd_op` = 2 (preset load) copies data register `cmd_sel` into the wiper register on that edge.
- R6: `cmd_op` = 3 (direct write) stores `cmd_data` into the wiper register.
- R7: `cmd_op` = 4 (save) copies the wiper value held before the edge into data register `cmd_sel`, in one cycle. Codes 0, 5, 6 and 7 do nothing.
- R8: With `step_en` high, the wiper moves up by one when `step_up` = 1 and down by one when `step_up` = 0, once per cycle.
- R9: A step up at 0xFF leaves 0xFF. A step down at 0x00 leaves 0x00. The value never wraps.
- R10: When a preset load or direct write falls in the same cycle as a step, the load wins and the step is ignored. A save or preset write in the same cycle does not block the step.
- R11: While `wp_n` is low, no data register and no wiper write, load or step takes effect. `rd_data` still returns data register `rd_sel`.
- R12: After reset, every data register holds 0x80. The wiper register holds the reset value of data register 0, which is 0x80, and `tap_sel` has bit 128 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wp_n | input | 1 | Write enable for all stored state; low protects |
| cmd_op | input | 3 | Operation: 0 idle, 1 preset write, 2 preset load, 3 direct write, 4 save |
| cmd_sel | input | 2 | Data register index for the operation |
| cmd_data | input | 8 | Data byte for preset write and direct write |
| step_en | input | 1 | Step strobe, one position per cycle |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| rd_sel | input | 2 | Data register index for read-back |
| rd_data | output | 8 | Contents of data register `rd_sel` |
| wiper_val | output | 8 | Wiper register |
| tap_sel | output | 256 | One-hot tap switch select |

## Verification
A wrong wiper register value reaches `wiper_val` and the tap select on the edge right after the fault. The bench's reference model detects it on the very next compare.

A wrong data register value stays hidden until that register is read back or loaded. The bench therefore sweeps `rd_sel` every cycle, so a corrupted preset shows within four cycles.

Decode faults appear as a missing bit, an extra bit or a misplaced bit in `tap_sel` in the same cycle as the wiper value they belong to. Saturation and priority faults appear one edge after a step at an end or a step that collides with a load.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE    = 3'd0,
    OP_DR_WR   = 3'd1,
    OP_DR_LOAD = 3'd2,
    OP_WCR_WR  = 3'd3,
    OP_SAVE    = 3'd4
  } wiper_op_e;
endpackage

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int W       = 8,
  parameter int NREG    = 4,
  parameter int RST_VAL = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_sel,
  input  logic [W-1:0]            wr_data,
  input  logic [$clog2(NREG)-1:0] ld_sel,
  output logic [W-1:0]            ld_data,
  input  logic [$clog2(NREG)-1:0] rd_sel,
  output logic [W-1:0]            rd_data,
  input  logic                    wp_n
);
  logic [NREG-1:0][W-1:0] regs_q;
  logic [NREG-1:0][W-1:0] regs_d;
  logic [NREG-1:0]        reg_ce;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_comb begin
        reg_ce[g] = wr_en && (wr_sel == g[$clog2(NREG)-1:0]);
        regs_d[g] = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         regs_q[g] <= W'(RST_VAL);
        else if (reg_ce[g]) regs_q[g] <= regs_d[g];
      end
    end
  endgenerate

  assign ld_data = regs_q[ld_sel];
  assign rd_data = regs_q[rd_sel];

  // R11
  bank_wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> $stable(regs_q));
endmodule

// File: rtl/wiper_counter.sv
module wiper_counter #(
  parameter int W       = 8,
  parameter int RST_VAL = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wp_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  input  logic         step_up,
  output logic         wcr_ce,
  output logic [W-1:0] wcr_d,
  output logic [W-1:0] wcr_q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] MINV = '0;

  always_comb begin
    wcr_ce = wp_n && (load_en || step_en);
    wcr_d  = wcr_q;
    if (load_en) begin
      wcr_d = load_val;
    end else if (step_en) begin
      if (step_up) begin
        if (wcr_q != MAXV) wcr_d = wcr_q + 1'b1;
      end else begin
        if (wcr_q != MINV) wcr_d = wcr_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcr_q <= W'(RST_VAL);
    else if (wcr_ce) wcr_q <= wcr_d;
  end

  // R8
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_n && step_en && step_up && !load_en && wcr_q != MAXV) |=> wcr_q == $past(wcr_q) + 1'b1);
  // R9
  no_wrap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_n && step_en && step_up && !load_en && wcr_q == MAXV) |=> wcr_q == MAXV);
  // R9
  no_wrap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_n && step_en && !step_up && !load_en && wcr_q == MINV) |=> wcr_q == MINV);
  // R11
  wcr_wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> $stable(wcr_q));
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int W       = 8,
  parameter int RST_VAL = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [W-1:0]      pos_d,
  output logic [2**W-1:0]   tap_q
);
  localparam int NTAP = 2**W;

  logic [NTAP-1:0] tap_d;

  generate
    for (genvar i = 0; i < NTAP; i++) begin : g_tap
      assign tap_d[i] = (pos_d == W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  tap_q[i] <= (i == RST_VAL);
        else if (ce) tap_q[i] <= tap_d[i];
      end
    end
  endgenerate

  // R3
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_q) == 1);
endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl #(
  parameter int W       = 8,
  parameter int NREG    = 4,
  parameter int RST_VAL = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wp_n,
  input  logic [2:0]              cmd_op,
  input  logic [$clog2(NREG)-1:0] cmd_sel,
  input  logic [W-1:0]            cmd_data,
  input  logic                    step_en,
  input  logic                    step_up,
  input  logic [$clog2(NREG)-1:0] rd_sel,
  output logic [W-1:0]            rd_data,
  output logic [W-1:0]            wiper_val,
  output logic [2**W-1:0]         tap_sel
);
  import wiper_pkg::*;

  logic [1:0]   rst_sync_q;
  logic         rst_int_n;
  wiper_op_e    op;
  logic         bank_we;
  logic [W-1:0] bank_wdata;
  logic [W-1:0] preset_val;
  logic         load_en;
  logic [W-1:0] load_val;
  logic         wcr_ce;
  logic [W-1:0] wcr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    op         = wiper_op_e'(cmd_op);
    bank_we    = wp_n && (op == OP_DR_WR || op == OP_SAVE);
    bank_wdata = (op == OP_SAVE) ? wiper_val : cmd_data;
    load_en    = (op == OP_DR_LOAD) || (op == OP_WCR_WR);
    load_val   = (op == OP_DR_LOAD) ? preset_val : cmd_data;
  end

  wiper_bank #(.W(W), .NREG(NREG), .RST_VAL(RST_VAL)) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (bank_we),
    .wr_sel  (cmd_sel),
    .wr_data (bank_wdata),
    .ld_sel  (cmd_sel),
    .ld_data (preset_val),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .wp_n    (wp_n)
  );

  wiper_counter #(.W(W), .RST_VAL(RST_VAL)) u_counter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wp_n     (wp_n),
    .load_en  (load_en),
    .load_val (load_val),
    .step_en  (step_en),
    .step_up  (step_up),
    .wcr_ce   (wcr_ce),
    .wcr_d    (wcr_d),
    .wcr_q    (wiper_val)
  );

  wiper_tap_decode #(.W(W), .RST_VAL(RST_VAL)) u_decode (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ce    (wcr_ce),
    .pos_d (wcr_d),
    .tap_q (tap_sel)
  );

  // R2
  tap_match_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    tap_sel[wiper_val] == 1'b1);
  // R5
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wp_n && op == OP_DR_LOAD) |=> wiper_val == $past(preset_val));
  // R6
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wp_n && op == OP_WCR_WR) |=> wiper_val == $past(cmd_data));
endmodule

// File: tb/test_wiper_pos_ctrl.sv
module test_wiper_pos_ctrl;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wp_n;
  logic [2:0]   cmd_op;
  logic [1:0]   cmd_sel;
  logic [7:0]   cmd_data;
  logic         step_en;
  logic         step_up;
  logic [1:0]   rd_sel;
  logic [7:0]   rd_data;
  logic [7:0]   wiper_val;
  logic [255:0] tap_sel;

  int vectors = 0;
  int fails   = 0;
  int m_wcr;
  int m_dr[4];
  bit done = 0;

  always #10 clk = ~clk;

  wiper_pos_ctrl i_wiper_pos_ctrl (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .step_en(step_en), .step_up(step_up), .rd_sel(rd_sel),
    .rd_data(rd_data), .wiper_val(wiper_val), .tap_sel(tap_sel)
  );

  task automatic compare(string tag);
    logic [255:0] exp_tap;
    exp_tap = 256'b1 << m_wcr;
    vectors++;
    if (wiper_val !== 8'(m_wcr)) begin
      fails++;
      $display("FAIL %s wiper_val act %h exp %h", tag, wiper_val, 8'(m_wcr));
    end
    if (tap_sel !== exp_tap) begin
      fails++;
      $display("FAIL %s R2 R3 tap_sel act ones=%0d bit=%0d exp bit %0d", tag,
               $countones(tap_sel), tap_sel[m_wcr], m_wcr);
    end
    if (rd_data !== 8'(m_dr[rd_sel])) begin
      fails++;
      $display("FAIL %s R11 rd_data[%0d] act %h exp %h", tag, rd_sel, rd_data, 8'(m_dr[rd_sel]));
    end
  endtask

  // Called at a negative edge: drive, predict, wait one cycle, compare.
  task automatic cyc(int op, int sel, int data, bit se, bit su, bit wp, string tag);
    int old_wcr;
    cmd_op = 3'(op); cmd_sel = 2'(sel); cmd_data = 8'(data);
    step_en = se; step_up = su; wp_n = wp;
    rd_sel = 2'(vectors % 4);
    old_wcr = m_wcr;
    if (wp) begin
      if (op == 1) m_dr[sel] = data;
      if (op == 4) m_dr[sel] = old_wcr;
      if (op == 2)      m_wcr = m_dr[sel];
      else if (op == 3) m_wcr = data;
      else if (se) begin
        if (su && m_wcr < 255) m_wcr++;
        if (!su && m_wcr > 0)  m_wcr--;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wp_n = 1; cmd_op = 0; cmd_sel = 0; cmd_data = 0;
    step_en = 0; step_up = 0; rd_sel = 0;
    m_wcr = 128;
    foreach (m_dr[k]) m_dr[k] = 128;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R12: reset state, sweep all read ports
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 1, "R12 reset");
    // R4: write presets
    cyc(1, 0, 8'h11, 0, 0, 1, "R4");
    cyc(1, 1, 8'h00, 0, 0, 1, "R4");
    cyc(1, 2, 8'hFF, 0, 0, 1, "R4");
    cyc(1, 3, 8'h5A, 0, 0, 1, "R4");
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 1, "R4 readback");
    // R5: load each preset, R2 endpoints
    for (int k = 0; k < 4; k++) cyc(2, k, 0, 0, 0, 1, "R5 R2");
    // R6: direct writes
    cyc(3, 0, 8'h01, 0, 0, 1, "R6");
    cyc(3, 0, 8'hFE, 0, 0, 1, "R6");
    // R8 R9: step up to top and past it
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 1, 1, "R8 R9 up");
    // R7: save 0xFF into DR1
    cyc(4, 1, 0, 0, 0, 1, "R7");
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 1, "R7 readback");
    // R8 R9: go down to bottom and past it
    cyc(3, 0, 8'h02, 0, 0, 1, "R6");
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 0, 1, "R8 R9 down");
    // R10: load beats step; save does not block step
    cyc(2, 3, 0, 1, 1, 1, "R10 load vs step");
    cyc(3, 0, 8'h40, 1, 0, 1, "R10 write vs step");
    cyc(4, 2, 0, 1, 1, 1, "R10 save with step");
    cyc(1, 0, 8'h77, 1, 0, 1, "R10 wr with step");
    // R7: codes 5..7 idle
    for (int k = 5; k < 8; k++) cyc(k, 0, 8'h33, 0, 0, 1, "R7 idle code");
    // R11: write protect
    for (int k = 1; k < 5; k++) cyc(k, k % 4, 8'hC3, 1, k % 2, 0, "R11");
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 0, "R11 read");
    // R1: mixed random traffic
    for (int k = 0; k < 400; k++)
      cyc(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
          1'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0), "R1 mixed");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule